// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the status word that a NOR flash bank returns on reads while an internal program or erase is running. Command decoding sits elsewhere: it hands this block an already-decoded start pulse for a program or an erase. With that pulse come the most significant bit of the data being programmed and a flag saying whether the target is protected. While the operation runs, the read data path carries two status bits in place of array contents. One is a polarity bit that depends on the operation type. The other inverts on every read access. Once the operation finishes, array data comes back.

An erase can be suspended and resumed, and a program can run while the erase is suspended. A program or erase aimed only at protected sectors never reaches the array. The block stands in for it with a busy window of fixed length, counted in clock cycles, after which the bank reads normally again. Directly after any return to read mode, one read still carries stale low-order status bits with a valid top bit. The next read after that is fully valid.

Top module: `flash_status_gen`

## Requirements
- R1: After reset the block is idle: `busy` is 0 and `dout` equals `array_data`, and reads while idle change nothing.
- R2: During a program (normal, protected or inside suspend), `dout[7]` is the inverse of the captured `prog_msb`, and `dout[5:0]` read 0.
- R3: During an erase, from its start pulse (this covers the sector time-out window), `dout[7]` reads 0.
- R4: While an operation is active, `dout[6]` inverts once per rising edge of `rd_strobe` and holds otherwise. It is cleared to 0 when an operation starts.
- R5: `op_done` ends a running normal program or erase and returns the block to idle, with `busy` 0.
- R6: On each return to idle, `dout` equals {`array_data[7]`, last value of bit 6, six zeros} until the first falling edge of `rd_strobe`. From then on it equals `array_data`.
- R7: A program with `target_prot` set is busy for exactly PROT_PROG_CYC cycles, ignores `op_done`, and then returns to where it started.
- R8: An erase with `target_prot` set is busy for exactly PROT_ERASE_CYC cycles, ignores `op_done`, and then returns to idle.
- R9: `suspend_req` during an erase enters suspend. There `dout[7]` reads 1, `dout[6]` holds through reads, and `busy` stays 1. `resume_req` returns to erase, and bit 6 toggles again.
- R10: `start_prog` while suspended runs a program with program status and a toggling bit 6. Its `op_done` returns to suspend, not to idle.
- R11: Start pulses arriving during an active operation are ignored. When both start pulses come in the same cycle while idle, the erase wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_prog | input | 1 | Decoded program-accepted pulse |
| start_erase | input | 1 | Decoded erase-accepted pulse |
| prog_msb | input | 1 | Bit 7 of the byte being programmed, captured at start |
| target_prot | input | 1 | Target sector(s) protected, captured at start |
| suspend_req | input | 1 | Erase suspend request pulse |
| resume_req | input | 1 | Erase resume request pulse |
| op_done | input | 1 | Array operation completion pulse |
| rd_strobe | input | 1 | Read access strobe (high for a read) |
| array_data | input | DW | Data read from the array |
| dout | output | DW | Read data, status or array |
| busy | output | 1 | An operation or suspend is in progress |

## Verification
The bound checker watches several rules on every cycle. Erase status always reads 0 on bit 7, and program status keeps the low bits clear. Bit 6 holds whenever no read edge arrived, and it stays frozen with bit 7 high while suspended. A started operation ignores further start pulses, `op_done` ends a normal program, and the protected windows never outlast their parameter. Some behaviour appears only as a sequence, and only the bench's scenarios show it. That covers the polarity derived from the captured data bit, and the exact length of each protected window. It also covers the one stale read after completion, the hand-back from a suspended program to the suspended erase, and the priority of erase over program.

// File: rtl/flash_status_pkg.sv
// Shared types for the flash status generator.
// Assumes: state encoding is private to this block.
package flash_status_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_SUSP,
        ST_SPROG,
        ST_PPROG,
        ST_PERASE
    } fsg_state_t;

    // True for the states in which the read toggle bit advances.
    function automatic logic fsg_toggling(fsg_state_t s);
        return (s == ST_PROG) || (s == ST_ERASE) || (s == ST_SPROG) ||
               (s == ST_PPROG) || (s == ST_PERASE);
    endfunction

    // True for the states that report program polarity.
    function automatic logic fsg_is_prog(fsg_state_t s);
        return (s == ST_PROG) || (s == ST_SPROG) || (s == ST_PPROG);
    endfunction

endpackage

// File: rtl/fsg_ctrl.sv
// Operation sequencer: tracks program, erase, suspend and protected
// busy windows, and captures the program data polarity bit.
// Assumes: start, suspend, resume and done inputs are one-cycle pulses
// from an upstream command decoder; PROT_*_CYC >= 1.
module fsg_ctrl
    import flash_status_pkg::*;
#(
    parameter int PROT_PROG_CYC  = 50,
    parameter int PROT_ERASE_CYC = 20000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_prog,
    input  logic       start_erase,
    input  logic       prog_msb,
    input  logic       target_prot,
    input  logic       suspend_req,
    input  logic       resume_req,
    input  logic       op_done,
    output fsg_state_t state,
    output logic       prog_bit,
    output logic       op_start,
    output logic       to_idle
);

    localparam int MAXLEN = (PROT_PROG_CYC > PROT_ERASE_CYC) ? PROT_PROG_CYC : PROT_ERASE_CYC;
    localparam int CW     = $clog2(MAXLEN + 1);
    localparam logic [CW-1:0] PP_LOAD = CW'(PROT_PROG_CYC - 1);
    localparam logic [CW-1:0] PE_LOAD = CW'(PROT_ERASE_CYC - 1);

    fsg_state_t    nxt;
    logic [CW-1:0] cnt;
    logic          ld_cnt;
    logic [CW-1:0] ld_val;
    logic          cap;
    logic          ret_susp;
    logic          nxt_ret;

    // Next-state and window-load decode.
    always_comb begin
        nxt     = state;
        ld_cnt  = 1'b0;
        ld_val  = '0;
        cap     = 1'b0;
        nxt_ret = ret_susp;
        case (state)
            ST_IDLE: begin
                if (start_erase) begin
                    if (target_prot) begin
                        nxt    = ST_PERASE;
                        ld_cnt = 1'b1;
                        ld_val = PE_LOAD;
                    end else begin
                        nxt = ST_ERASE;
                    end
                end else if (start_prog) begin
                    cap     = 1'b1;
                    nxt_ret = 1'b0;
                    if (target_prot) begin
                        nxt    = ST_PPROG;
                        ld_cnt = 1'b1;
                        ld_val = PP_LOAD;
                    end else begin
                        nxt = ST_PROG;
                    end
                end
            end
            ST_PROG:   if (op_done) nxt = ST_IDLE;
            ST_ERASE: begin
                if (op_done)          nxt = ST_IDLE;
                else if (suspend_req) nxt = ST_SUSP;
            end
            ST_SUSP: begin
                if (start_prog) begin
                    cap     = 1'b1;
                    nxt_ret = 1'b1;
                    if (target_prot) begin
                        nxt    = ST_PPROG;
                        ld_cnt = 1'b1;
                        ld_val = PP_LOAD;
                    end else begin
                        nxt = ST_SPROG;
                    end
                end else if (resume_req) begin
                    nxt = ST_ERASE;
                end
            end
            ST_SPROG:  if (op_done) nxt = ST_SUSP;
            ST_PPROG:  if (cnt == '0) nxt = ret_susp ? ST_SUSP : ST_IDLE;
            ST_PERASE: if (cnt == '0) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    assign op_start = ((state == ST_IDLE) && (start_erase || start_prog)) ||
                      ((state == ST_SUSP) && start_prog);
    assign to_idle  = (nxt == ST_IDLE) && (state != ST_IDLE);

    // State, return flag and captured polarity registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ret_susp <= 1'b0;
            prog_bit <= 1'b0;
        end else begin
            state    <= nxt;
            ret_susp <= nxt_ret;
            if (cap) prog_bit <= prog_msb;
        end
    end

    // Protected-window down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (ld_cnt)     cnt <= ld_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

endmodule

// File: rtl/fsg_toggle.sv
// Read-strobe edge detector and status toggle bit.
// Assumes: rd_strobe is synchronous to clk and held for at least a cycle.
module fsg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_strobe,
    input  logic clr,
    input  logic adv_en,
    output logic tog,
    output logic rd_fall
);

    logic rd_q;
    logic rd_rise;

    assign rd_rise = rd_strobe & ~rd_q;
    assign rd_fall = ~rd_strobe & rd_q;

    // Delayed strobe for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_strobe;
    end

    // Toggle bit: cleared on start, inverted per read while active.
    always_ff @(posedge clk) begin
        if (!rst_n)                  tog <= 1'b0;
        else if (clr)                tog <= 1'b0;
        else if (adv_en && rd_rise)  tog <= ~tog;
    end

endmodule

// File: rtl/fsg_outmux.sv
// Read data selection: status word while active, a one-read settle word
// after completion, array data otherwise.
// Assumes: DW >= 3; polarity sits in the top bit, toggle just below it.
module fsg_outmux
    import flash_status_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fsg_state_t    state,
    input  logic          prog_bit,
    input  logic          tog,
    input  logic          to_idle,
    input  logic          rd_fall,
    input  logic [DW-1:0] array_data,
    output logic [DW-1:0] dout
);

    localparam int POL_BIT = DW - 1;
    localparam int TOG_BIT = DW - 2;

    logic          settle;
    logic          pol;
    logic [DW-1:0] status_w;
    logic [DW-1:0] settle_w;

    // Settle flag: set on return to idle, cleared when a read ends.
    always_ff @(posedge clk) begin
        if (!rst_n)       settle <= 1'b0;
        else if (to_idle) settle <= 1'b1;
        else if (rd_fall) settle <= 1'b0;
    end

    // Polarity bit by operation type.
    always_comb begin
        if (fsg_is_prog(state))    pol = ~prog_bit;
        else if (state == ST_SUSP) pol = 1'b1;
        else                       pol = 1'b0;
    end

    // Assemble the status and settle words, then select.
    always_comb begin
        status_w          = '0;
        status_w[POL_BIT] = pol;
        status_w[TOG_BIT] = tog;
        settle_w          = '0;
        settle_w[POL_BIT] = array_data[POL_BIT];
        settle_w[TOG_BIT] = tog;
        if (state != ST_IDLE) dout = status_w;
        else if (settle)      dout = settle_w;
        else                  dout = array_data;
    end

endmodule

// File: rtl/flash_status_gen.sv
// Top of the flash status generator: sequencer, toggle bit and read mux.
// Assumes: decoded command pulses and a synchronous read strobe.
module flash_status_gen
    import flash_status_pkg::*;
#(
    parameter int DW             = 8,
    parameter int PROT_PROG_CYC  = 50,
    parameter int PROT_ERASE_CYC = 20000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_prog,
    input  logic          start_erase,
    input  logic          prog_msb,
    input  logic          target_prot,
    input  logic          suspend_req,
    input  logic          resume_req,
    input  logic          op_done,
    input  logic          rd_strobe,
    input  logic [DW-1:0] array_data,
    output logic [DW-1:0] dout,
    output logic          busy
);

    fsg_state_t state;
    logic       prog_bit;
    logic       op_start;
    logic       to_idle;
    logic       tog;
    logic       rd_fall;
    logic       adv_en;

    assign adv_en = fsg_toggling(state);
    assign busy   = (state != ST_IDLE);

    fsg_ctrl #(
        .PROT_PROG_CYC (PROT_PROG_CYC),
        .PROT_ERASE_CYC(PROT_ERASE_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_prog (start_prog),
        .start_erase(start_erase),
        .prog_msb   (prog_msb),
        .target_prot(target_prot),
        .suspend_req(suspend_req),
        .resume_req (resume_req),
        .op_done    (op_done),
        .state      (state),
        .prog_bit   (prog_bit),
        .op_start   (op_start),
        .to_idle    (to_idle)
    );

    fsg_toggle u_tog (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_strobe(rd_strobe),
        .clr      (op_start),
        .adv_en   (adv_en),
        .tog      (tog),
        .rd_fall  (rd_fall)
    );

    fsg_outmux #(.DW(DW)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .prog_bit  (prog_bit),
        .tog       (tog),
        .to_idle   (to_idle),
        .rd_fall   (rd_fall),
        .array_data(array_data),
        .dout      (dout)
    );

endmodule

// File: rtl/flash_status_gen_chk.sv
// Property checker for flash_status_gen, attached by bind.
module flash_status_gen_chk
    import flash_status_pkg::*;
#(
    parameter int DW             = 8,
    parameter int PROT_PROG_CYC  = 50,
    parameter int PROT_ERASE_CYC = 20000
) (
    input logic          clk,
    input logic          rst_n,
    input fsg_state_t    state,
    input logic [DW-1:0] dout,
    input logic          rd_strobe,
    input logic          busy,
    input logic          op_done,
    input logic          start_prog,
    input logic          start_erase,
    input logic          suspend_req
);

    int pp_cnt;
    int pe_cnt;

    // Cycles spent in each protected window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pp_cnt <= 0;
            pe_cnt <= 0;
        end else begin
            pp_cnt <= (state == ST_PPROG)  ? pp_cnt + 1 : 0;
            pe_cnt <= (state == ST_PERASE) ? pe_cnt + 1 : 0;
        end
    end

    // R3
    erase_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE) |-> !dout[DW-1]);

    // R2
    prog_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsg_is_prog(state) |-> (dout[DW-3:0] == '0));

    // R4
    tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsg_toggling(state) && state == $past(state) &&
         !($past(rd_strobe) && !$past(rd_strobe, 2))) |-> $stable(dout[DW-2]));

    // R9
    susp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP && $past(state) == ST_SUSP) |->
            ($stable(dout[DW-2]) && dout[DW-1] && busy));

    // R5
    prog_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && op_done) |=> !busy);

    // R11
    erase_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE && (start_prog || start_erase) && !op_done && !suspend_req)
            |=> (state == ST_ERASE));

    // R7
    pprog_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pp_cnt <= PROT_PROG_CYC);

    // R8
    perase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pe_cnt <= PROT_ERASE_CYC);

endmodule

bind flash_status_gen flash_status_gen_chk #(
    .DW            (DW),
    .PROT_PROG_CYC (PROT_PROG_CYC),
    .PROT_ERASE_CYC(PROT_ERASE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .dout       (dout),
    .rd_strobe  (rd_strobe),
    .busy       (busy),
    .op_done    (op_done),
    .start_prog (start_prog),
    .start_erase(start_erase),
    .suspend_req(suspend_req)
);

// File: tb/test_flash_status_gen.sv
// Directed bench for flash_status_gen: one task per scenario.
module test_flash_status_gen;

    localparam int PPC = 50;
    localparam int PEC = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_prog = 1'b0;
    logic       start_erase = 1'b0;
    logic       prog_msb = 1'b0;
    logic       target_prot = 1'b0;
    logic       suspend_req = 1'b0;
    logic       resume_req = 1'b0;
    logic       op_done = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] array_data = 8'h5A;
    logic [7:0] dout;
    logic       busy;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    flash_status_gen #(.DW(8), .PROT_PROG_CYC(PPC), .PROT_ERASE_CYC(PEC)) i_flash_status_gen (
        .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
        .prog_msb(prog_msb), .target_prot(target_prot), .suspend_req(suspend_req),
        .resume_req(resume_req), .op_done(op_done), .rd_strobe(rd_strobe),
        .array_data(array_data), .dout(dout), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic go_prog(input logic msb, input logic prot);
        @(negedge clk);
        prog_msb = msb; target_prot = prot; start_prog = 1'b1;
        @(negedge clk);
        start_prog = 1'b0;
    endtask

    task automatic go_erase(input logic prot);
        @(negedge clk);
        target_prot = prot; start_erase = 1'b1;
        @(negedge clk);
        start_erase = 1'b0;
    endtask

    task automatic go_done();
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
    endtask

    task automatic go_suspend();
        @(negedge clk); suspend_req = 1'b1;
        @(negedge clk); suspend_req = 1'b0;
    endtask

    task automatic go_resume();
        @(negedge clk); resume_req = 1'b1;
        @(negedge clk); resume_req = 1'b0;
    endtask

    task automatic do_read(output logic [7:0] seen);
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); seen = dout; rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        chk("R1 reset busy", busy, 0);
        chk("R1 reset dout", dout, 8'h5A);
        do_read(s);
        chk("R1 idle read", s, 8'h5A);
        chk("R1 idle after read", dout, 8'h5A);
    endtask

    task automatic t_program();
        logic [7:0] s;
        array_data = 8'hC3;
        go_prog(1'b1, 1'b0);
        chk("R2 prog busy", busy, 1);
        chk("R2 prog status", dout, 8'h00);
        do_read(s); chk("R4 prog read1", s, 8'h40);
        do_read(s); chk("R4 prog read2", s, 8'h00);
        repeat (3) @(negedge clk);
        chk("R4 no read hold", dout, 8'h00);
        go_done();
        chk("R5 prog done busy", busy, 0);
        chk("R6 settle word", dout, 8'h80);
        do_read(s); chk("R6 settle read", s, 8'h80);
        chk("R6 after settle", dout, 8'hC3);
        go_prog(1'b0, 1'b0);
        chk("R2 prog inverse", dout, 8'h80);
        do_read(s); chk("R4 prog toggle", s, 8'hC0);
        go_done();
        chk("R6 settle tog1", dout, 8'hC0);
        do_read(s);
        chk("R6 array back", dout, 8'hC3);
    endtask

    task automatic t_erase();
        logic [7:0] s;
        array_data = 8'h3C;
        go_erase(1'b0);
        chk("R3 erase status", dout, 8'h00);
        chk("R4 start cleared", dout[6], 0);
        do_read(s); chk("R4 erase read1", s, 8'h40);
        do_read(s); chk("R4 erase read2", s, 8'h00);
        do_read(s); chk("R3 erase read3", s, 8'h40);
        go_done();
        chk("R5 erase done", busy, 0);
        chk("R6 erase settle", dout, 8'h40);
        do_read(s);
        chk("R6 erase array", dout, 8'h3C);
    endtask

    task automatic t_suspend();
        logic [7:0] s;
        array_data = 8'h3C;
        go_erase(1'b0);
        do_read(s); chk("R4 pre-suspend", s, 8'h40);
        go_suspend();
        chk("R9 suspend word", dout, 8'hC0);
        chk("R9 suspend busy", busy, 1);
        do_read(s); chk("R9 suspend read1", s, 8'hC0);
        do_read(s); chk("R9 suspend read2", s, 8'hC0);
        go_prog(1'b0, 1'b0);
        chk("R10 sprog status", dout, 8'h80);
        do_read(s); chk("R10 sprog toggle", s, 8'hC0);
        go_done();
        chk("R10 back to suspend", dout, 8'hC0);
        chk("R10 still busy", busy, 1);
        go_resume();
        chk("R9 resumed erase", dout, 8'h40);
        do_read(s); chk("R9 resumed toggle", s, 8'h00);
        go_done();
        chk("R6 after resume done", dout, 8'h00);
        do_read(s);
        chk("R6 array after resume", dout, 8'h3C);
    endtask

    task automatic t_prot_prog();
        logic [7:0] s;
        int n;
        array_data = 8'hA5;
        go_prog(1'b1, 1'b1);
        chk("R7 fake prog status", dout, 8'h00);
        n = 0;
        while (busy && n < PPC + 10) begin
            if (n == 3) op_done = 1'b1;
            if (n == 4) op_done = 1'b0;
            n++;
            @(negedge clk);
        end
        chk("R7 window length", n, PPC);
        chk("R7 settle", dout, 8'h80);
        do_read(s);
        chk("R7 data unchanged", dout, 8'hA5);
    endtask

    task automatic t_prot_erase();
        logic [7:0] s;
        int n;
        array_data = 8'hA5;
        go_erase(1'b1);
        chk("R8 fake erase status", dout, 8'h00);
        n = 0;
        while (busy && n < PEC + 10) begin
            if (n == 7) op_done = 1'b1;
            if (n == 8) op_done = 1'b0;
            n++;
            @(negedge clk);
        end
        chk("R8 window length", n, PEC);
        do_read(s);
        chk("R8 data unchanged", dout, 8'hA5);
    endtask

    task automatic t_priority();
        logic [7:0] s;
        array_data = 8'h3C;
        @(negedge clk);
        prog_msb = 1'b0; target_prot = 1'b0; start_prog = 1'b1; start_erase = 1'b1;
        @(negedge clk);
        start_prog = 1'b0; start_erase = 1'b0;
        chk("R11 erase wins", dout, 8'h00);
        go_prog(1'b0, 1'b0);
        chk("R11 prog ignored", dout, 8'h00);
        chk("R11 still busy", busy, 1);
        go_erase(1'b0);
        chk("R11 erase ignored", dout, 8'h00);
        go_done();
        do_read(s);
        chk("R11 idle after", dout, 8'h3C);
    endtask

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_erase();
        t_suspend();
        t_prot_prog();
        t_prot_erase();
        t_priority();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule